// File: doc/BRIEF.md
# Bandwidth-Limited Retire Controller

This block decides, each cycle, which instructions leave the head of a reorder buffer for one thread. The buffer shows a window of its oldest entries for the thread named by an external grant. The controller walks that window in age order. It removes squashed entries, commits finished ones up to a configurable per-cycle width, and stops at the first entry it cannot retire. An entry that must run without speculation, an uncached load or a faulting entry stops the walk. Such an entry produces a request instead: a non-speculative execute request, an uncached-load request or a trap request.

The retire decision is combinational, so the buffer can pop the marked entries at the next clock edge. The per-thread program counter, the per-thread trap-pending flag and the statistics are registered. A trap-pending thread retires nothing until its trap squash input arrives. When entries leave the buffer, the controller also broadcasts the thread's new free-entry count and an empty flag.

Top module: `retire_ctl`

## Requirements
- R1: At most COMMIT_W non-squashed entries commit per cycle. The walk stops at the first slot that is not valid or not ready, and at any slot reached once COMMIT_W entries have committed, even a squashed one. Without a grant, or while the granted thread has a trap pending, nothing pops. Popped slots always form a run starting at slot 0.
- R2: A ready squashed entry pops without counting toward COMMIT_W. Each one adds 1 to the squashed-retire counter.
- R3: An unexecuted entry that is non-speculative, store-conditional or a barrier stalls the walk with no request while stores_pend is 1 or an earlier slot committed this cycle. Otherwise it raises nspec_vld with its sequence number, uncached=0 and clr_cancommit=1, and the walk stops.
- R4: An unexecuted load that is not squashed raises nspec_vld with its sequence number, uncached=1 and clr_cancommit=1, and the walk stops. Neither stores_pend nor slot position stalls it.
- R5: A faulting executed entry stalls under the same conditions as R3. Otherwise trap_req rises with trap_tid equal to the granted thread, and the walk stops. That thread's trap_pend bit is 1 from the next cycle until the cycle after its trap_squash bit is 1.
- R6: On commit, done_vld=1 and done_seq is the sequence number of the youngest committed entry. After the clock edge, the granted thread's entry in thr_pc holds that entry's next PC. Thread t's PC sits at thr_pc[t*PC_W +: PC_W].
- R7: Committed entries flagged nop or instruction prefetch pop and count toward COMMIT_W. They do not add to st_committed, which counts every other committed entry.
- R8: Every cycle out of reset, histogram bin commit_cnt adds 1. Bin b sits at st_hist[b*CNT_W +: CNT_W], for b from 0 to COMMIT_W. st_full adds 1 in cycles where commit_cnt equals COMMIT_W.
- R9: free_vld is 1 only in cycles where pop_cnt > 0. free_cnt is then thr_free + pop_cnt, and rob_empty is 1 when free_cnt equals DEPTH.
- R10: After reset, every thread's PC is RESET_PC, no trap is pending, and all counters and histogram bins are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant_vld | input | 1 | A thread is granted this cycle |
| grant_tid | input | TID_W | Granted thread |
| head_vld | input | WIN | Window slot holds an entry (slot 0 oldest) |
| head_rdy | input | WIN | Entry may be considered for retirement |
| head_sq | input | WIN | Entry is squashed |
| head_exe | input | WIN | Entry has executed |
| head_nspec | input | WIN | Entry is non-speculative |
| head_stc | input | WIN | Entry is a store-conditional |
| head_bar | input | WIN | Entry is a memory or write barrier |
| head_ld | input | WIN | Entry is a load |
| head_flt | input | WIN | Entry carries a fault |
| head_nop | input | WIN | Entry is a nop |
| head_pf | input | WIN | Entry is an instruction prefetch |
| head_seq | input | WIN*SEQ_W | Sequence numbers, slot i at [i*SEQ_W +: SEQ_W] |
| head_npc | input | WIN*PC_W | Next PC of each slot |
| stores_pend | input | 1 | Stores still await write-back |
| thr_free | input | FREE_W | Granted thread's free entries before this cycle's pops |
| trap_squash | input | NTHR | Per-thread trap squash, clears trap pending |
| pop_mask | output | WIN | Slots removed this cycle |
| pop_cnt | output | PCNT_W | Number of slots removed |
| commit_cnt | output | CW | Non-squashed entries committed |
| done_vld | output | 1 | At least one entry committed |
| done_seq | output | SEQ_W | Sequence number of youngest committed entry |
| nspec_vld | output | 1 | Non-speculative or uncached execute request |
| nspec_seq | output | SEQ_W | Sequence number for the request |
| uncached | output | 1 | Request is an uncached load |
| clr_cancommit | output | 1 | Clear can-commit on first unpopped slot |
| trap_req | output | 1 | Trap request |
| trap_tid | output | TID_W | Thread of the trap request |
| free_vld | output | 1 | Free-entry broadcast valid |
| free_cnt | output | FREE_W | Free entries after pops |
| rob_empty | output | 1 | Thread's buffer share is empty |
| thr_pc | output | NTHR*PC_W | Per-thread committed PC |
| trap_pend | output | NTHR | Per-thread trap pending |
| st_committed | output | CNT_W | Committed entries excluding nops and prefetches |
| st_squashed | output | CNT_W | Squashed entries removed |
| st_full | output | CNT_W | Cycles with full commit width used |
| st_hist | output | (COMMIT_W+1)*CNT_W | Commits-per-cycle histogram |

## Verification
The walk is driven with windows of plain entries longer than the width, windows with squashed entries mixed between plain ones, windows cut short by a not-ready slot, and no grant. These show the width limit apart from the squash bypass and from the readiness stop. Serializing and faulting entries are placed in slot 0 and behind a commit, each with and without pending stores, so the first-slot rule and the store-drain rule are each seen on their own. Uncached loads, nop and prefetch entries, a buffer about to empty, and a trap on one thread followed by retirement on the other show the request encodings, the statistic exclusions and the per-thread state.

// File: rtl/rtr_pkg.sv
package rtr_pkg;

   typedef enum logic [2:0] {
      ACT_STOP     = 3'd0,
      ACT_DROP     = 3'd1,
      ACT_COMMIT   = 3'd2,
      ACT_NSPEC    = 3'd3,
      ACT_UNCACHED = 3'd4,
      ACT_TRAP     = 3'd5,
      ACT_WAIT     = 3'd6
   } rtr_act_e;

   typedef struct packed {
      logic sq;
      logic exe;
      logic ser;
      logic ld;
      logic flt;
   } rtr_attr_t;

   function automatic rtr_act_e rtr_classify(input rtr_attr_t a,
                                             input logic first,
                                             input logic st_pend);
      rtr_act_e act;
      if (a.sq)
         act = ACT_DROP;
      else if (!a.exe) begin
         if (a.ser)
            act = (first && !st_pend) ? ACT_NSPEC : ACT_WAIT;
         else if (a.ld)
            act = ACT_UNCACHED;
         else
            act = ACT_WAIT;
      end else if (a.flt)
         act = (first && !st_pend) ? ACT_TRAP : ACT_WAIT;
      else
         act = ACT_COMMIT;
      return act;
   endfunction

endpackage

// File: rtl/rtr_scan.sv
module rtr_scan
   import rtr_pkg::*;
#(
   parameter int COMMIT_W = 2,
   parameter int WIN      = 4,
   parameter int SEQ_W    = 16,
   parameter int PC_W     = 32,
   localparam int CW      = $clog2(COMMIT_W + 1),
   localparam int SW      = $clog2(WIN + 1)
) (
   input  logic             en,
   input  logic [WIN-1:0]   vld,
   input  logic [WIN-1:0]   rdy,
   input  rtr_attr_t        attr [WIN],
   input  logic [WIN-1:0]   uncounted,
   input  logic [WIN*SEQ_W-1:0] seq,
   input  logic [WIN*PC_W-1:0]  npc,
   input  logic             st_pend,
   output logic [WIN-1:0]   pop,
   output logic [CW-1:0]    ncommit,
   output logic [CW-1:0]    ncounted,
   output logic [SW-1:0]    nsquash,
   output logic             done_vld,
   output logic [SEQ_W-1:0] done_seq,
   output logic [PC_W-1:0]  last_npc,
   output logic             req_vld,
   output logic             req_unc,
   output logic [SEQ_W-1:0] req_seq,
   output logic             trap_hit
);

   rtr_act_e act;
   logic     alive;

   always_comb begin
      pop      = '0;
      ncommit  = '0;
      ncounted = '0;
      nsquash  = '0;
      done_vld = 1'b0;
      done_seq = '0;
      last_npc = '0;
      req_vld  = 1'b0;
      req_unc  = 1'b0;
      req_seq  = '0;
      trap_hit = 1'b0;
      alive    = en;
      act      = ACT_STOP;
      for (int i = 0; i < WIN; i++) begin
         if (alive) begin
            if (!vld[i] || !rdy[i] || ncommit == CW'(COMMIT_W)) begin
               alive = 1'b0;
            end else begin
               act = rtr_classify(attr[i], ncommit == '0, st_pend);
               case (act)
                  ACT_DROP: begin
                     pop[i]  = 1'b1;
                     nsquash = nsquash + SW'(1);
                  end
                  ACT_COMMIT: begin
                     pop[i]   = 1'b1;
                     ncommit  = ncommit + CW'(1);
                     if (!uncounted[i])
                        ncounted = ncounted + CW'(1);
                     done_vld = 1'b1;
                     done_seq = seq[i*SEQ_W +: SEQ_W];
                     last_npc = npc[i*PC_W +: PC_W];
                  end
                  ACT_NSPEC, ACT_UNCACHED: begin
                     req_vld = 1'b1;
                     req_unc = (act == ACT_UNCACHED);
                     req_seq = seq[i*SEQ_W +: SEQ_W];
                     alive   = 1'b0;
                  end
                  ACT_TRAP: begin
                     trap_hit = 1'b1;
                     alive    = 1'b0;
                  end
                  default: alive = 1'b0;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/rtr_thr_state.sv
module rtr_thr_state #(
   parameter int          NTHR     = 2,
   parameter int          PC_W     = 32,
   parameter int unsigned RESET_PC = 'h100,
   localparam int         TID_W    = (NTHR > 1) ? $clog2(NTHR) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_vld,
   input  logic [TID_W-1:0]   upd_tid,
   input  logic [PC_W-1:0]    upd_pc,
   input  logic               trap_set,
   input  logic [NTHR-1:0]    trap_squash,
   output logic [NTHR*PC_W-1:0] pc_flat,
   output logic [NTHR-1:0]    pend
);

   for (genvar t = 0; t < NTHR; t++) begin : g_thr
      logic [PC_W-1:0] pc_q;
      logic            pend_q;
      wire             hit = (upd_tid == TID_W'(t));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_q   <= PC_W'(RESET_PC);
            pend_q <= 1'b0;
         end else begin
            if (upd_vld && hit)
               pc_q <= upd_pc;
            if (trap_set && hit)
               pend_q <= 1'b1;
            else if (trap_squash[t])
               pend_q <= 1'b0;
         end
      end

      assign pc_flat[t*PC_W +: PC_W] = pc_q;
      assign pend[t] = pend_q;
   end

   // R5
   trap_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_set |=> pend[$past(upd_tid)]);

   // R5
   trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trap_set && trap_squash[0]) |=> !pend[0]);

endmodule

// File: rtl/rtr_stats.sv
module rtr_stats #(
   parameter int COMMIT_W = 2,
   parameter int WIN      = 4,
   parameter int CNT_W    = 16,
   localparam int CW      = $clog2(COMMIT_W + 1),
   localparam int SW      = $clog2(WIN + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [CW-1:0]               ncommit,
   input  logic [CW-1:0]               ncounted,
   input  logic [SW-1:0]               nsquash,
   output logic [CNT_W-1:0]            committed,
   output logic [CNT_W-1:0]            squashed,
   output logic [CNT_W-1:0]            full,
   output logic [(COMMIT_W+1)*CNT_W-1:0] hist
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         committed <= '0;
         squashed  <= '0;
         full      <= '0;
      end else begin
         committed <= committed + CNT_W'(ncounted);
         squashed  <= squashed + CNT_W'(nsquash);
         if (ncommit == CW'(COMMIT_W))
            full <= full + CNT_W'(1);
      end
   end

   for (genvar b = 0; b <= COMMIT_W; b++) begin : g_bin
      logic [CNT_W-1:0] bin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bin_q <= '0;
         else if (ncommit == CW'(b))
            bin_q <= bin_q + CNT_W'(1);
      end
      assign hist[b*CNT_W +: CNT_W] = bin_q;
   end

   // R8
   full_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ncommit == CW'(COMMIT_W)) |=> (full == $past(full) + CNT_W'(1)));

   // R8
   bin0_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ncommit == '0) |=> (hist[CNT_W-1:0] == $past(hist[CNT_W-1:0]) + CNT_W'(1)));

endmodule

// File: rtl/retire_ctl.sv
module retire_ctl
   import rtr_pkg::*;
#(
   parameter int          COMMIT_W = 2,
   parameter int          WIN      = 4,
   parameter int          NTHR     = 2,
   parameter int          DEPTH    = 32,
   parameter int          SEQ_W    = 16,
   parameter int          PC_W     = 32,
   parameter int          CNT_W    = 16,
   parameter int unsigned RESET_PC = 'h100,
   localparam int         TID_W    = (NTHR > 1) ? $clog2(NTHR) : 1,
   localparam int         CW       = $clog2(COMMIT_W + 1),
   localparam int         PCNT_W   = $clog2(WIN + 1),
   localparam int         FREE_W   = $clog2(DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 grant_vld,
   input  logic [TID_W-1:0]     grant_tid,
   input  logic [WIN-1:0]       head_vld,
   input  logic [WIN-1:0]       head_rdy,
   input  logic [WIN-1:0]       head_sq,
   input  logic [WIN-1:0]       head_exe,
   input  logic [WIN-1:0]       head_nspec,
   input  logic [WIN-1:0]       head_stc,
   input  logic [WIN-1:0]       head_bar,
   input  logic [WIN-1:0]       head_ld,
   input  logic [WIN-1:0]       head_flt,
   input  logic [WIN-1:0]       head_nop,
   input  logic [WIN-1:0]       head_pf,
   input  logic [WIN*SEQ_W-1:0] head_seq,
   input  logic [WIN*PC_W-1:0]  head_npc,
   input  logic                 stores_pend,
   input  logic [FREE_W-1:0]    thr_free,
   input  logic [NTHR-1:0]      trap_squash,
   output logic [WIN-1:0]       pop_mask,
   output logic [PCNT_W-1:0]    pop_cnt,
   output logic [CW-1:0]        commit_cnt,
   output logic                 done_vld,
   output logic [SEQ_W-1:0]     done_seq,
   output logic                 nspec_vld,
   output logic [SEQ_W-1:0]     nspec_seq,
   output logic                 uncached,
   output logic                 clr_cancommit,
   output logic                 trap_req,
   output logic [TID_W-1:0]     trap_tid,
   output logic                 free_vld,
   output logic [FREE_W-1:0]    free_cnt,
   output logic                 rob_empty,
   output logic [NTHR*PC_W-1:0] thr_pc,
   output logic [NTHR-1:0]      trap_pend,
   output logic [CNT_W-1:0]     st_committed,
   output logic [CNT_W-1:0]     st_squashed,
   output logic [CNT_W-1:0]     st_full,
   output logic [(COMMIT_W+1)*CNT_W-1:0] st_hist
);

   if (COMMIT_W < 1 || WIN < COMMIT_W) begin : g_bad_width
      $error("retire_ctl: need 1 <= COMMIT_W <= WIN");
   end
   if (WIN > DEPTH || NTHR < 1) begin : g_bad_depth
      $error("retire_ctl: need WIN <= DEPTH and NTHR >= 1");
   end

   rtr_attr_t         attr [WIN];
   logic [WIN-1:0]    uncounted;
   logic              tid_ok;
   logic              scan_en;
   logic [CW-1:0]     ncounted;
   logic [PCNT_W-1:0] nsquash;
   logic [PC_W-1:0]   last_npc;
   logic              req_vld;
   logic              req_unc;

   for (genvar i = 0; i < WIN; i++) begin : g_attr
      assign attr[i] = '{sq:  head_sq[i],
                         exe: head_exe[i],
                         ser: head_nspec[i] | head_stc[i] | head_bar[i],
                         ld:  head_ld[i],
                         flt: head_flt[i]};
      assign uncounted[i] = head_nop[i] | head_pf[i];
   end

   assign tid_ok  = (int'(grant_tid) < NTHR);
   assign scan_en = grant_vld && tid_ok && !trap_pend[grant_tid];

   rtr_scan #(.COMMIT_W(COMMIT_W), .WIN(WIN), .SEQ_W(SEQ_W), .PC_W(PC_W)) u_scan (
      .en       (scan_en),
      .vld      (head_vld),
      .rdy      (head_rdy),
      .attr     (attr),
      .uncounted(uncounted),
      .seq      (head_seq),
      .npc      (head_npc),
      .st_pend  (stores_pend),
      .pop      (pop_mask),
      .ncommit  (commit_cnt),
      .ncounted (ncounted),
      .nsquash  (nsquash),
      .done_vld (done_vld),
      .done_seq (done_seq),
      .last_npc (last_npc),
      .req_vld  (req_vld),
      .req_unc  (req_unc),
      .req_seq  (nspec_seq),
      .trap_hit (trap_req)
   );

   assign nspec_vld     = req_vld;
   assign uncached      = req_unc;
   assign clr_cancommit = req_vld;
   assign trap_tid      = grant_tid;
   assign pop_cnt       = PCNT_W'(commit_cnt) + nsquash;
   assign free_vld      = (pop_cnt != '0);
   assign free_cnt      = free_vld ? (thr_free + FREE_W'(pop_cnt)) : '0;
   assign rob_empty     = free_vld && (free_cnt == FREE_W'(DEPTH));

   rtr_thr_state #(.NTHR(NTHR), .PC_W(PC_W), .RESET_PC(RESET_PC)) u_thr (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_vld    (done_vld),
      .upd_tid    (grant_tid),
      .upd_pc     (last_npc),
      .trap_set   (trap_req),
      .trap_squash(trap_squash),
      .pc_flat    (thr_pc),
      .pend       (trap_pend)
   );

   rtr_stats #(.COMMIT_W(COMMIT_W), .WIN(WIN), .CNT_W(CNT_W)) u_stats (
      .clk      (clk),
      .rst_n    (rst_n),
      .ncommit  (commit_cnt),
      .ncounted (ncounted),
      .nsquash  (nsquash),
      .committed(st_committed),
      .squashed (st_squashed),
      .full     (st_full),
      .hist     (st_hist)
   );

   // R1
   width_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_cnt <= CW'(COMMIT_W));

   // R1
   pop_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pop_mask & (pop_mask + WIN'(1))) == '0));

   // R5
   pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld && tid_ok && trap_pend[grant_tid]) |-> (pop_mask == '0 && !trap_req && !nspec_vld));

   // R3
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nspec_vld, trap_req}));

   // R3
   drain_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nspec_vld && !uncached) |-> (!stores_pend && commit_cnt == '0));

   // R9
   bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_mask == '0) |-> (!free_vld && !rob_empty));

endmodule

// File: tb/test_retire_ctl.sv
module test_retire_ctl;

   localparam int W      = 2;
   localparam int WIN    = 4;
   localparam int NTHR   = 2;
   localparam int DEPTH  = 32;
   localparam int SEQ_W  = 16;
   localparam int PC_W   = 32;
   localparam int CNT_W  = 16;
   localparam int RPC    = 'h100;
   localparam int TID_W  = 1;
   localparam int FREE_W = $clog2(DEPTH + 1);

   typedef enum int {K_NORM, K_SQ, K_NSPEC, K_STC, K_BAR, K_LD, K_FLT,
                     K_NOP, K_PF} kind_e;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                 grant_vld;
   logic [TID_W-1:0]     grant_tid;
   logic [WIN-1:0]       h_vld, h_rdy, h_sq, h_exe, h_nspec, h_stc, h_bar,
                         h_ld, h_flt, h_nop, h_pf;
   logic [WIN*SEQ_W-1:0] h_seq;
   logic [WIN*PC_W-1:0]  h_npc;
   logic                 stores_pend;
   logic [FREE_W-1:0]    thr_free;
   logic [NTHR-1:0]      trap_squash;

   logic [WIN-1:0]       pop_mask;
   logic [2:0]           pop_cnt;
   logic [1:0]           commit_cnt;
   logic                 done_vld, nspec_vld, uncached, clr_cancommit;
   logic                 trap_req, free_vld, rob_empty;
   logic [SEQ_W-1:0]     done_seq, nspec_seq;
   logic [TID_W-1:0]     trap_tid;
   logic [FREE_W-1:0]    free_cnt;
   logic [NTHR*PC_W-1:0] thr_pc;
   logic [NTHR-1:0]      trap_pend;
   logic [CNT_W-1:0]     st_committed, st_squashed, st_full;
   logic [(W+1)*CNT_W-1:0] st_hist;

   retire_ctl #(.COMMIT_W(W), .WIN(WIN), .NTHR(NTHR), .DEPTH(DEPTH),
                .SEQ_W(SEQ_W), .PC_W(PC_W), .CNT_W(CNT_W), .RESET_PC(RPC))
   i_retire_ctl (
      .clk(clk), .rst_n(rst_n), .grant_vld(grant_vld), .grant_tid(grant_tid),
      .head_vld(h_vld), .head_rdy(h_rdy), .head_sq(h_sq), .head_exe(h_exe),
      .head_nspec(h_nspec), .head_stc(h_stc), .head_bar(h_bar), .head_ld(h_ld),
      .head_flt(h_flt), .head_nop(h_nop), .head_pf(h_pf), .head_seq(h_seq),
      .head_npc(h_npc), .stores_pend(stores_pend), .thr_free(thr_free),
      .trap_squash(trap_squash), .pop_mask(pop_mask), .pop_cnt(pop_cnt),
      .commit_cnt(commit_cnt), .done_vld(done_vld), .done_seq(done_seq),
      .nspec_vld(nspec_vld), .nspec_seq(nspec_seq), .uncached(uncached),
      .clr_cancommit(clr_cancommit), .trap_req(trap_req), .trap_tid(trap_tid),
      .free_vld(free_vld), .free_cnt(free_cnt), .rob_empty(rob_empty),
      .thr_pc(thr_pc), .trap_pend(trap_pend), .st_committed(st_committed),
      .st_squashed(st_squashed), .st_full(st_full), .st_hist(st_hist)
   );

   int total = 0;
   int bad = 0;
   logic [CNT_W-1:0] s_com, s_sq, s_full;
   logic [(W+1)*CNT_W-1:0] s_hist;

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic longint bin(input logic [(W+1)*CNT_W-1:0] h, input int b);
      return longint'(h[b*CNT_W +: CNT_W]);
   endfunction

   function automatic longint pc_of(input int t);
      return longint'(thr_pc[t*PC_W +: PC_W]);
   endfunction

   task automatic idle();
      grant_vld = 1'b0; grant_tid = '0;
      h_vld = '0; h_rdy = '0; h_sq = '0; h_exe = '0; h_nspec = '0; h_stc = '0;
      h_bar = '0; h_ld = '0; h_flt = '0; h_nop = '0; h_pf = '0;
      h_seq = '0; h_npc = '0; stores_pend = 1'b0; thr_free = '0;
      trap_squash = '0;
   endtask

   task automatic put(input int s, input kind_e k, input int sq, input int npc);
      h_vld[s] = 1'b1; h_rdy[s] = 1'b1;
      h_exe[s] = !(k inside {K_NSPEC, K_STC, K_BAR, K_LD});
      h_sq[s]    = (k == K_SQ);
      h_nspec[s] = (k == K_NSPEC);
      h_stc[s]   = (k == K_STC);
      h_bar[s]   = (k == K_BAR);
      h_ld[s]    = (k == K_LD);
      h_flt[s]   = (k == K_FLT);
      h_nop[s]   = (k == K_NOP);
      h_pf[s]    = (k == K_PF);
      h_seq[s*SEQ_W +: SEQ_W] = SEQ_W'(sq);
      h_npc[s*PC_W +: PC_W]   = PC_W'(npc);
   endtask

   task automatic begin_cycle(input int tid);
      @(negedge clk);
      idle();
      grant_vld = 1'b1; grant_tid = TID_W'(tid); thr_free = FREE_W'(10);
   endtask

   task automatic snap();
      #1;
      s_com = st_committed; s_sq = st_squashed; s_full = st_full; s_hist = st_hist;
   endtask

   task automatic end_cycle();
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      check("R10 pc0", pc_of(0), RPC);
      check("R10 pc1", pc_of(1), RPC);
      check("R10 trap_pend", trap_pend, 0);
      check("R10 committed", st_committed, 0);
      check("R10 squashed", st_squashed, 0);
      check("R10 full", st_full, 0);
      check("R10 bin2", bin(st_hist, 2), 0);
      check("R1 idle pop", pop_mask, 0);
   endtask

   task automatic t_width();
      begin_cycle(0);
      put(0, K_NORM, 10, 'h200); put(1, K_NORM, 11, 'h204); put(2, K_NORM, 12, 'h208);
      snap();
      check("R1 width pop", pop_mask, 4'b0011);
      check("R1 width commit", commit_cnt, 2);
      check("R6 done_vld", done_vld, 1);
      check("R6 done_seq", done_seq, 11);
      check("R9 free_vld", free_vld, 1);
      check("R9 free_cnt", free_cnt, 12);
      check("R9 not empty", rob_empty, 0);
      end_cycle();
      check("R6 pc", pc_of(0), 'h204);
      check("R8 full", st_full, s_full + 1);
      check("R8 bin2", bin(st_hist, 2), bin(s_hist, 2) + 1);
      check("R7 committed", st_committed, s_com + 2);
   endtask

   task automatic t_squash();
      begin_cycle(0);
      put(0, K_SQ, 20, 0); put(1, K_NORM, 21, 'h300); put(2, K_SQ, 22, 0);
      put(3, K_NORM, 23, 'h304);
      snap();
      check("R2 pop all", pop_mask, 4'b1111);
      check("R2 pop_cnt", pop_cnt, 4);
      check("R2 commit", commit_cnt, 2);
      check("R2 done_seq", done_seq, 23);
      end_cycle();
      check("R2 squashed stat", st_squashed, s_sq + 2);
      check("R2 pc", pc_of(0), 'h304);
      // squashed entry after width is reached stays
      begin_cycle(0);
      put(0, K_NORM, 24, 'h308); put(1, K_NORM, 25, 'h30c); put(2, K_SQ, 26, 0);
      snap();
      check("R1 squash after width", pop_mask, 4'b0011);
      end_cycle();
      check("R2 no extra squash", st_squashed, s_sq);
   endtask

   task automatic t_stops();
      begin_cycle(0);
      grant_vld = 1'b0;
      put(0, K_NORM, 30, 'h400);
      snap();
      check("R1 no grant pop", pop_mask, 0);
      check("R9 no grant bcast", free_vld, 0);
      end_cycle();
      check("R8 bin0", bin(st_hist, 0), bin(s_hist, 0) + 1);
      check("R6 pc held", pc_of(0), 'h30c);
      begin_cycle(0);
      put(0, K_NORM, 31, 'h404); put(1, K_NORM, 32, 'h408); h_rdy[1] = 1'b0;
      put(2, K_NORM, 33, 'h40c);
      snap();
      check("R1 not ready stop", pop_mask, 4'b0001);
      check("R6 done seq", done_seq, 31);
      end_cycle();
      check("R8 bin1", bin(st_hist, 1), bin(s_hist, 1) + 1);
      check("R8 full held", st_full, s_full);
   endtask

   task automatic t_serial();
      begin_cycle(0);
      put(0, K_NSPEC, 40, 0); stores_pend = 1'b1;
      snap();
      check("R3 wait stores pop", pop_mask, 0);
      check("R3 wait stores req", nspec_vld, 0);
      end_cycle();
      begin_cycle(0);
      put(0, K_BAR, 41, 0);
      snap();
      check("R3 req", nspec_vld, 1);
      check("R3 seq", nspec_seq, 41);
      check("R3 cached", uncached, 0);
      check("R3 clear", clr_cancommit, 1);
      end_cycle();
      begin_cycle(0);
      put(0, K_NORM, 42, 'h500); put(1, K_STC, 43, 0);
      snap();
      check("R3 second slot pop", pop_mask, 4'b0001);
      check("R3 second slot req", nspec_vld, 0);
      end_cycle();
   endtask

   task automatic t_uncached();
      begin_cycle(0);
      put(0, K_NORM, 50, 'h600); put(1, K_LD, 51, 0); put(2, K_NORM, 52, 'h608);
      stores_pend = 1'b1;
      snap();
      check("R4 pop", pop_mask, 4'b0001);
      check("R4 req", nspec_vld, 1);
      check("R4 seq", nspec_seq, 51);
      check("R4 uncached", uncached, 1);
      check("R4 clear", clr_cancommit, 1);
      end_cycle();
   endtask

   task automatic t_fault();
      begin_cycle(0);
      put(0, K_FLT, 60, 0); stores_pend = 1'b1;
      snap();
      check("R5 wait stores", trap_req, 0);
      end_cycle();
      begin_cycle(0);
      put(0, K_NORM, 61, 'h700); put(1, K_FLT, 62, 0);
      snap();
      check("R5 second slot", trap_req, 0);
      check("R5 second slot pop", pop_mask, 4'b0001);
      end_cycle();
      begin_cycle(0);
      put(0, K_FLT, 62, 0);
      snap();
      check("R5 trap", trap_req, 1);
      check("R5 trap tid", trap_tid, 0);
      check("R5 trap pop", pop_mask, 0);
      end_cycle();
      check("R5 pend set", trap_pend, 2'b01);
      begin_cycle(0);
      put(0, K_NORM, 63, 'h704);
      snap();
      check("R5 pend blocks", pop_mask, 0);
      end_cycle();
      begin_cycle(0);
      trap_squash = 2'b01;
      snap();
      end_cycle();
      check("R5 pend cleared", trap_pend, 0);
      begin_cycle(0);
      put(0, K_NORM, 63, 'h704);
      snap();
      check("R5 resumes", pop_mask, 4'b0001);
      end_cycle();
      check("R6 pc after trap", pc_of(0), 'h704);
   endtask

   task automatic t_nop();
      begin_cycle(0);
      put(0, K_NOP, 70, 'h800); put(1, K_PF, 71, 'h804);
      snap();
      check("R7 commit count", commit_cnt, 2);
      end_cycle();
      check("R7 nop pf excluded", st_committed, s_com);
      check("R7 full", st_full, s_full + 1);
      begin_cycle(0);
      put(0, K_NOP, 72, 'h808); put(1, K_NORM, 73, 'h80c);
      snap();
      end_cycle();
      check("R7 mixed", st_committed, s_com + 1);
   endtask

   task automatic t_empty_thr1();
      begin_cycle(1);
      thr_free = FREE_W'(DEPTH - 2);
      put(0, K_NORM, 80, 'h900); put(1, K_SQ, 81, 0);
      snap();
      check("R9 free", free_cnt, DEPTH);
      check("R9 empty", rob_empty, 1);
      end_cycle();
      check("R6 thread1 pc", pc_of(1), 'h900);
      check("R6 thread0 pc kept", pc_of(0), 'h80c);
   endtask

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      t_reset();
      t_width();
      t_squash();
      t_stops();
      t_serial();
      t_uncached();
      t_fault();
      t_nop();
      t_empty_thr1();
      @(negedge clk);
      idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule